// File: doc/BRIEF.md
# Voice Run and End-Interrupt Control

This block holds the run state and end-of-buffer interrupt state for two banks of audio voices. Each bank keeps one running bit per voice, and these bits feed the address generators of the voice engines. Each bank also has one interrupt-enable bit and one latched end-status bit per voice. Software sets voices running through a start register and halts them through a separate stop register. In both registers only the bits written as one take effect.

When a voice engine reports the end of its buffer, the event is latched as a status bit, but only if that voice's enable bit is set. Software clears a status bit by writing one to it. A global control register holds a gate bit. When the gate is set, any enabled pending status bit in either bank raises the summary interrupt line. The same condition also shows in a miscellaneous status register that the service routine reads first. Register writes take effect on the next clock edge. Register reads are combinational from the current address.

Top module: `voice_run_irq_ctrl`

## Requirements
- R1: After reset, all running, enable and status bits and the global control register are zero, and `irq_o` is low.
- R2: A write to the start register (bank 0 at 0x80, bank 1 at 0xB4) sets the running bit of every voice whose data bit is one. Bits written as zero are left unchanged. A read of the start register returns the current running bits, which are also driven on `run_a_o` / `run_b_o`.
- R3: A write to the stop register (bank 0 at 0x84, bank 1 at 0xB8) clears the running bit of every voice whose data bit is one. Bits written as zero are left unchanged. A read of the stop register returns zero.
- R4: An end event on a voice input sets that voice's status bit only when its enable bit is set.
- R5: A write to the status register (bank 0 at 0x98, bank 1 at 0xD8) clears each bit written as one and leaves each bit written as zero unchanged.
- R6: If an enabled end event and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R7: `irq_o` is high exactly when bit 12 of the global control register (0xA0, read/write) is set and at least one status bit in either bank has its enable bit set.
- R8: Bit 5 of the miscellaneous status register (0xB0, read-only) equals `irq_o`. All its other bits read zero.
- R9: The enable registers (bank 0 at 0xA4, bank 1 at 0xDC) are plain read/write. The two banks are independent: a write to one bank's registers and events on one bank's inputs leave the other bank's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| end_evt_a_i | input | 32 | Per-voice end-of-buffer events, bank 0 |
| end_evt_b_i | input | 32 | Per-voice end-of-buffer events, bank 1 |
| run_a_o | output | 32 | Running bits, bank 0 |
| run_b_o | output | 32 | Running bits, bank 1 |
| irq_o | output | 1 | Summary voice-end interrupt |

## Verification
The start and stop registers are driven with overlapping masks. This shows that set and clear are masked by the written ones and are not plain loads. The status register is cleared first with all-zero data, then with a non-matching mask, then with the matching bit. This tells a true write-one-to-clear apart from a load or a full clear.

An end event is applied with the voice's enable clear and then with it set. This shows the enable qualifying the latch. An event that arrives in the same cycle as a clear of the same bit shows which of the two wins. The interrupt line is observed with the gate clear, with the gate set, and with the enable removed while status is still pending. This separates the gate and the enable from the raw status. Bank 1 stimulus at its high voice bit confirms the separate decode for each bank and the OR across the two banks.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int NUM_BANKS = 2;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int GATE_BIT  = 12;
  localparam int PEND_BIT  = 5;

  localparam logic [ADDR_W-1:0] GCTL_OFF = 8'hA0;
  localparam logic [ADDR_W-1:0] MISC_OFF = 8'hB0;

  typedef enum logic [1:0] {K_START, K_STOP, K_ISTS, K_IEN} reg_kind_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic ists;
    logic ien;
  } bank_we_t;

  function automatic logic [ADDR_W-1:0] bank_off(input int bank, input reg_kind_e kind);
    logic [ADDR_W-1:0] r;
    if (bank == 0) begin
      case (kind)
        K_START: r = 8'h80;
        K_STOP:  r = 8'h84;
        K_ISTS:  r = 8'h98;
        default: r = 8'hA4;
      endcase
    end else begin
      case (kind)
        K_START: r = 8'hB4;
        K_STOP:  r = 8'hB8;
        K_ISTS:  r = 8'hD8;
        default: r = 8'hDC;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/vrc_decode.sv
module vrc_decode
  import vrc_pkg::*;
#(
  parameter int NV = 32
) (
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output bank_we_t [NUM_BANKS-1:0]       bank_we_o,
  output logic                           gctl_we_o,
  input  logic [NUM_BANKS-1:0][NV-1:0]   run_i,
  input  logic [NUM_BANKS-1:0][NV-1:0]   ists_i,
  input  logic [NUM_BANKS-1:0][NV-1:0]   ien_i,
  input  logic [REG_W-1:0]               gctl_i,
  input  logic                           pend_i,
  output logic [REG_W-1:0]               rdata_o
);
  always_comb begin
    bank_we_o = '0;
    gctl_we_o = we_i && (addr_i == GCTL_OFF);
    rdata_o   = '0;
    if (addr_i == GCTL_OFF) rdata_o = gctl_i;
    if (addr_i == MISC_OFF) rdata_o[PEND_BIT] = pend_i;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == bank_off(b, K_START)) begin
        bank_we_o[b].start = we_i;
        rdata_o = REG_W'(run_i[b]);
      end
      if (addr_i == bank_off(b, K_STOP)) begin
        bank_we_o[b].stop = we_i;
      end
      if (addr_i == bank_off(b, K_ISTS)) begin
        bank_we_o[b].ists = we_i;
        rdata_o = REG_W'(ists_i[b]);
      end
      if (addr_i == bank_off(b, K_IEN)) begin
        bank_we_o[b].ien = we_i;
        rdata_o = REG_W'(ien_i[b]);
      end
    end
  end
endmodule

// File: rtl/vrc_bank.sv
module vrc_bank
  import vrc_pkg::*;
#(
  parameter int NV = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bank_we_t      we_i,
  input  logic [NV-1:0] wdata_i,
  input  logic [NV-1:0] end_evt_i,
  output logic [NV-1:0] run_o,
  output logic [NV-1:0] ists_o,
  output logic [NV-1:0] ien_o,
  output logic          pend_o
);
  logic [NV-1:0] run_q, ists_q, ien_q;
  logic [NV-1:0] set_m, clr_m, iclr_m;

  assign set_m  = we_i.start ? wdata_i : '0;
  assign clr_m  = we_i.stop  ? wdata_i : '0;
  assign iclr_m = we_i.ists  ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      ists_q <= '0;
      ien_q  <= '0;
    end else begin
      run_q  <= (run_q | set_m) & ~clr_m;
      // enabled event wins over a same-cycle clear
      ists_q <= (ists_q & ~iclr_m) | (end_evt_i & ien_q);
      if (we_i.ien) ien_q <= wdata_i;
    end
  end

  assign run_o  = run_q;
  assign ists_o = ists_q;
  assign ien_o  = ien_q;
  assign pend_o = |(ists_q & ien_q);

  assert_start_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i.start |=> ((run_q & $past(wdata_i)) == $past(wdata_i)));
  assert_stop_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i.stop |=> ((run_q & $past(wdata_i)) == '0));
  assert_set_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ists_q & ~$past(ists_q)) & ~$past(end_evt_i & ien_q)) == '0);
  assert_evt_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~ists_q & $past(end_evt_i & ien_q)) == '0);
endmodule

// File: rtl/vrc_irq_sum.sv
module vrc_irq_sum
  import vrc_pkg::*;
(
  input  logic [NUM_BANKS-1:0] pend_i,
  input  logic                 gate_i,
  output logic                 irq_o
);
  assign irq_o = gate_i & (|pend_i);
endmodule

// File: rtl/voice_run_irq_ctrl.sv
module voice_run_irq_ctrl
  import vrc_pkg::*;
#(
  parameter int NV = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NV-1:0]     end_evt_a_i,
  input  logic [NV-1:0]     end_evt_b_i,
  output logic [NV-1:0]     run_a_o,
  output logic [NV-1:0]     run_b_o,
  output logic              irq_o
);
  bank_we_t [NUM_BANKS-1:0]     bank_we;
  logic [NUM_BANKS-1:0][NV-1:0] run, ists, ien, evt;
  logic [NUM_BANKS-1:0]         pend;
  logic [REG_W-1:0]             gctl_q;
  logic                         gctl_we;

  assign evt[0] = end_evt_a_i;
  assign evt[1] = end_evt_b_i;

  vrc_decode #(.NV(NV)) u_dec (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .bank_we_o(bank_we), .gctl_we_o(gctl_we),
    .run_i(run), .ists_i(ists), .ien_i(ien), .gctl_i(gctl_q), .pend_i(irq_o),
    .rdata_o(reg_rdata_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vrc_bank #(.NV(NV)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bank_we[b]), .wdata_i(reg_wdata_i[NV-1:0]),
      .end_evt_i(evt[b]), .run_o(run[b]), .ists_o(ists[b]), .ien_o(ien[b]),
      .pend_o(pend[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gctl_q <= '0;
    else if (gctl_we) gctl_q <= reg_wdata_i;
  end

  vrc_irq_sum u_sum (.pend_i(pend), .gate_i(gctl_q[GATE_BIT]), .irq_o(irq_o));

  assign run_a_o = run[0];
  assign run_b_o = run[1];

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gctl_q[GATE_BIT]);
  assert_irq_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ists[0] & ien[0]) != '0 || (ists[1] & ien[1]) != '0));
  assert_misc_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == MISC_OFF) |-> (reg_rdata_o == (32'(irq_o) << PEND_BIT)));
endmodule

// File: tb/voice_run_irq_ctrl_bench.sv
module voice_run_irq_ctrl_bench;
  logic        clk = 0, rst_ni = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, evt_a = 0, evt_b = 0;
  logic [31:0] rdata, run_a, run_b;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  event smp_ev;

  always #5 clk = ~clk;

  voice_run_irq_ctrl u_voice_run_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .end_evt_a_i(evt_a), .end_evt_b_i(evt_b),
    .run_a_o(run_a), .run_b_o(run_b), .irq_o(irq));

  // monitor: kind 0 = read data, 1 = irq, 2 = run_a, 3 = run_b
  initial forever begin
    @(smp_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {31'd0, irq};
        2: act = run_a;
        default: act = run_b;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    addr = a; #1;
    q.push_back('{0, e, r}); ->smp_ev; #1;
  endtask

  task automatic exp_sig(input int k, input logic [31:0] e, input string r);
    q.push_back('{k, e, r}); ->smp_ev; #1;
  endtask

  task automatic pulse_a(input logic [31:0] m);
    @(negedge clk); evt_a = m; @(negedge clk); evt_a = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    exp_rd(8'h80, 0, "R1 run a");
    exp_rd(8'h98, 0, "R1 ists a");
    exp_rd(8'hA0, 0, "R1 gctl");
    exp_sig(1, 0, "R1 irq");
    // R2 start masks
    wr(8'h80, 32'h0000_00F1);
    exp_rd(8'h80, 32'h0000_00F1, "R2 start read");
    wr(8'h80, 32'h0000_0100);
    exp_sig(2, 32'h0000_01F1, "R2 zeros ignored");
    // R3 stop
    exp_rd(8'h84, 0, "R3 stop reads zero");
    wr(8'h84, 32'h0000_0011);
    exp_sig(2, 32'h0000_01E0, "R3 stop masks");
    // R4 event without enable
    pulse_a(32'h8);
    exp_rd(8'h98, 0, "R4 no enable no latch");
    wr(8'hA4, 32'h8);
    exp_rd(8'hA4, 32'h8, "R9 enable readback");
    pulse_a(32'h8);
    exp_rd(8'h98, 32'h8, "R4 enabled latch");
    exp_sig(1, 0, "R7 gate off");
    exp_rd(8'hB0, 0, "R8 misc gate off");
    wr(8'hA0, 32'h0000_1000);
    exp_sig(1, 1, "R7 gate on");
    exp_rd(8'hB0, 32'h20, "R8 misc pending");
    // R5 write-one-to-clear
    wr(8'h98, 32'h0);
    exp_rd(8'h98, 32'h8, "R5 zero write");
    wr(8'h98, 32'h4);
    exp_rd(8'h98, 32'h8, "R5 other bit");
    wr(8'h98, 32'h8);
    exp_rd(8'h98, 0, "R5 cleared");
    exp_sig(1, 0, "R7 cleared irq low");
    // R6 same-cycle event and clear
    @(negedge clk); evt_a = 32'h8; we = 1; addr = 8'h98; wdata = 32'h8;
    @(negedge clk); evt_a = 0; we = 0; wdata = 0;
    exp_rd(8'h98, 32'h8, "R6 event wins");
    // R7 enable removed while pending
    wr(8'hA4, 32'h0);
    exp_sig(1, 0, "R7 enable masks pending");
    exp_rd(8'h98, 32'h8, "R7 status kept");
    // R9 bank B
    wr(8'hB4, 32'h8000_0000);
    exp_sig(3, 32'h8000_0000, "R9 run b");
    exp_sig(2, 32'h0000_01E0, "R9 run a untouched");
    wr(8'hDC, 32'h8000_0000);
    @(negedge clk); evt_b = 32'h8000_0000; @(negedge clk); evt_b = 0;
    exp_rd(8'hD8, 32'h8000_0000, "R9 ists b");
    exp_sig(1, 1, "R7 irq from bank b");
    exp_rd(8'hB8, 0, "R3 stop b reads zero");
    wr(8'hA0, 32'h0);
    exp_sig(1, 0, "R7 gate off bank b");
    exp_rd(8'hB0, 0, "R8 misc cleared");
    done = 1;
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule